// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects up to 32 interrupt sources and turns them into two prioritised request lines and one wake indication. Each source is synchronised by two flops and then qualified by a 3-bit trigger code. The code selects rising-edge, falling-edge, either-edge, active-high level or active-low level detection, or switches the source off. Edge events are held in per-source rising and falling capture latches until software clears them. Level sources follow the synchronised input directly and are never latched.

Software drives the block through a small register bus with an address, a write strobe, write data and combinational read data. Every control register has three addresses: one for reading, one where written 1s set bits, and one where written 1s clear bits. A bit written as 0 therefore never disturbs a neighbour, and no read-modify-write is needed. A per-source mask bit gates the request lines. A wake-enable bit gates the wake output. An assign bit steers each source to request 0, the higher-priority line, or to request 1. Two read-only pending registers show which qualified sources are active on each line.

Top module: `irq_ctrl`

## Requirements
- R1: The trigger code of source i is {trigHi[i], trigMid[i], trigLo[i]}. Code 101 makes the source pending while its synchronised input is 1. Code 110 makes it pending while the input is 0. Neither level mode latches anything.
- R2: Code 001 captures rising edges, 010 captures falling edges and 011 captures both. A captured edge keeps the source pending after the input returns to its idle level.
- R3: Registers are reached through group = addr[5:2] and sub = addr[1:0]. The control groups are 0 trigLo, 1 trigMid, 2 trigHi, 3 mask, 4 wake, 5 assign and 6 source-select. For each of them, sub 1 sets every bit written as 1, sub 2 clears every bit written as 1, and bits written as 0 keep their value. A read at any address of the group returns the register.
- R4: Group 7 (read 0x1C, clear 0x1E) is the rising capture latch and group 8 (read 0x20, clear 0x22) is the falling capture latch. A both-edge source stays pending until both of its latches are cleared.
- R5: A source can drive a request line only while its mask bit is 1. Code 000 captures nothing and never makes the source pending.
- R6: A qualified source with assign bit 1 drives req0. One with assign bit 0 drives req1.
- R7: Group 9 (0x24) reads pending AND mask AND assign. Group 10 (0x28) reads pending AND mask AND NOT assign. Each request output is the OR of its pending register.
- R8: wakeOut is the OR over all sources of pending AND wake bit, and it does not depend on the mask.
- R9: After reset every control register and both latch registers read 0, and req0, req1 and wakeOut are 0 whatever the inputs do.
- R10: If an edge capture and a clear of the same latch bit fall in the same cycle, the latch bit ends up set.
- R11: Group 11 is a scratch test register: a write at 0x2D stores the whole word, and a read at 0x2C returns it. It resets to 0.
- R12: The reserved codes 100 and 111 never make a source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Asynchronous interrupt source inputs |
| busAddr | input | 6 | Register address, group in bits 5:2, sub-address in bits 1:0 |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| req0 | output | 1 | High-priority request line |
| req1 | output | 1 | Low-priority request line |
| wakeOut | output | 1 | Wake indication |

## Verification
The assertions assume that the bus presents at most one write per cycle and that write data is stable at the clock edge. They also assume that an edge can only be captured from values that have already passed through both synchroniser flops. The bench changes srcIn and all bus signals at the falling clock edge, so these assumptions hold. It holds every input level for at least four cycles, so each edge is fully captured before the next register access, and its edge model can count events without tracking cycles. The one exception is the directed collision case, which places a latch clear exactly in the capture cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W  = 6;
  localparam int NUM_CTL = 7;
  localparam logic [3:0] G_TRIGLO = 4'd0;
  localparam logic [3:0] G_TRIGMID = 4'd1;
  localparam logic [3:0] G_TRIGHI = 4'd2;
  localparam logic [3:0] G_MASK = 4'd3;
  localparam logic [3:0] G_WAKE = 4'd4;
  localparam logic [3:0] G_ASGN = 4'd5;
  localparam logic [3:0] G_SRCSEL = 4'd6;
  localparam logic [3:0] G_RISE = 4'd7;
  localparam logic [3:0] G_FALL = 4'd8;
  localparam logic [3:0] G_PEND0 = 4'd9;
  localparam logic [3:0] G_PEND1 = 4'd10;
  localparam logic [3:0] G_TEST = 4'd11;

  typedef struct packed {
    logic [NUM_CTL-1:0] setEn;
    logic [NUM_CTL-1:0] clrEn;
    logic               riseClr;
    logic               fallClr;
    logic               testWr;
    logic [3:0]         rdGroup;
  } busStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strb
);
  logic [3:0] group;
  logic [1:0] sub;

  assign group = busAddr[ADDR_W-1:2];
  assign sub   = busAddr[1:0];

  always_comb begin
    strb = '0;
    strb.rdGroup = group;
    if (busWrEn) begin
      for (int g = 0; g < NUM_CTL; g++) begin
        if (group == 4'(g)) begin
          strb.setEn[g] = (sub == 2'd1);
          strb.clrEn[g] = (sub == 2'd2);
        end
      end
      strb.riseClr = (group == G_RISE) && (sub == 2'd2);
      strb.fallClr = (group == G_FALL) && (sub == 2'd2);
      strb.testWr  = (group == G_TEST) && (sub == 2'd1);
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  busStrobe_t         strb,
  output logic [NUM_SRC-1:0] rdData,
  output logic               req0,
  output logic               req1,
  output logic               wakeOut
);
  logic [NUM_SRC-1:0] ctlReg [NUM_CTL];
  logic [NUM_SRC-1:0] syncA, syncB, syncPrev;
  logic [NUM_SRC-1:0] riseLat, fallLat, riseDet, fallDet;
  logic [NUM_SRC-1:0] pend, pend0, pend1, testReg;

  // control registers with set/clear write ports (R3)
  for (genvar g = 0; g < NUM_CTL; g++) begin : gCtl
    always_ff @(posedge clk) begin
      if (!rstN) ctlReg[g] <= '0;
      else if (strb.setEn[g]) ctlReg[g] <= ctlReg[g] | wrData;
      else if (strb.clrEn[g]) ctlReg[g] <= ctlReg[g] & ~wrData;
    end
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rstN)
      strb.setEn[g] |=> ((ctlReg[g] & $past(wrData)) == $past(wrData)) &&
                        ((ctlReg[g] & ~$past(wrData)) == ($past(ctlReg[g]) & ~$past(wrData))));
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrEn[g] |=> ((ctlReg[g] & $past(wrData)) == '0) &&
                        ((ctlReg[g] & ~$past(wrData)) == ($past(ctlReg[g]) & ~$past(wrData))));
  end

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncPrev <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      syncPrev <= syncB;
    end
  end

  // per-source qualification (R1, R2, R12)
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic lo, mid, hi, lvlHit, edgeHit;
    assign lo  = ctlReg[G_TRIGLO][i];
    assign mid = ctlReg[G_TRIGMID][i];
    assign hi  = ctlReg[G_TRIGHI][i];
    assign riseDet[i] = ~hi & lo & syncB[i] & ~syncPrev[i];
    assign fallDet[i] = ~hi & mid & ~syncB[i] & syncPrev[i];
    assign lvlHit  = hi & (lo ^ mid) & (lo ? syncB[i] : ~syncB[i]);
    assign edgeHit = ~hi & ((lo & riseLat[i]) | (mid & fallLat[i]));
    assign pend[i] = lvlHit | edgeHit;
  end

  // capture latches: a new edge beats a same-cycle clear (R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseLat <= '0;
      fallLat <= '0;
    end else begin
      riseLat <= (riseLat & ~(strb.riseClr ? wrData : '0)) | riseDet;
      fallLat <= (fallLat & ~(strb.fallClr ? wrData : '0)) | fallDet;
    end
  end

  a_r10_rise_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    (riseDet != '0) |=> ((riseLat & $past(riseDet)) == $past(riseDet)));
  a_r10_fall_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    (fallDet != '0) |=> ((fallLat & $past(fallDet)) == $past(fallDet)));

  always_ff @(posedge clk) begin
    if (!rstN) testReg <= '0;
    else if (strb.testWr) testReg <= wrData;
  end

  // routing and outputs (R5, R6, R7, R8)
  assign pend0   = pend & ctlReg[G_MASK] & ctlReg[G_ASGN];
  assign pend1   = pend & ctlReg[G_MASK] & ~ctlReg[G_ASGN];
  assign req0    = |pend0;
  assign req1    = |pend1;
  assign wakeOut = |(pend & ctlReg[G_WAKE]);

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReg[G_MASK] == '0) |-> (!req0 && !req1));
  a_r6_req0_needs_assign: assert property (@(posedge clk) disable iff (!rstN)
    req0 |-> (ctlReg[G_ASGN] != '0));
  a_r8_wake_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReg[G_WAKE] == '0) |-> !wakeOut);

  always_comb begin
    rdData = '0;
    case (strb.rdGroup)
      G_TRIGLO:  rdData = ctlReg[G_TRIGLO];
      G_TRIGMID: rdData = ctlReg[G_TRIGMID];
      G_TRIGHI:  rdData = ctlReg[G_TRIGHI];
      G_MASK:    rdData = ctlReg[G_MASK];
      G_WAKE:    rdData = ctlReg[G_WAKE];
      G_ASGN:    rdData = ctlReg[G_ASGN];
      G_SRCSEL:  rdData = ctlReg[G_SRCSEL];
      G_RISE:    rdData = riseLat;
      G_FALL:    rdData = fallLat;
      G_PEND0:   rdData = pend0;
      G_PEND1:   rdData = pend1;
      G_TEST:    rdData = testReg;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               req0,
  output logic               req1,
  output logic               wakeOut
);
  busStrobe_t strb;

  irqc_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .wrData  (busWrData),
    .strb    (strb),
    .rdData  (busRdData),
    .req0    (req0),
    .req1    (req1),
    .wakeOut (wakeOut)
  );
endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [31:0] srcIn;
  logic [5:0] busAddr;
  logic busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic req0, req1, wakeOut;

  int nChk = 0;
  int nFail = 0;
  logic [31:0] mReg [7];
  logic [31:0] mRise, mFall, mTest, mIn;

  irq_ctrl uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .req0(req0), .req1(req1), .wakeOut(wakeOut)
  );

  function automatic logic [31:0] expPend();
    logic [31:0] p;
    p = '0;
    for (int i = 0; i < 32; i++) begin
      case ({mReg[2][i], mReg[1][i], mReg[0][i]})
        3'b001: p[i] = mRise[i];
        3'b010: p[i] = mFall[i];
        3'b011: p[i] = mRise[i] | mFall[i];
        3'b101: p[i] = mIn[i];
        3'b110: p[i] = ~mIn[i];
        default: p[i] = 1'b0;
      endcase
    end
    return p;
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    int g;
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    g = int'(a[5:2]);
    if (g < 7 && a[1:0] == 2'd1) mReg[g] = mReg[g] | d;
    if (g < 7 && a[1:0] == 2'd2) mReg[g] = mReg[g] & ~d;
    if (g == 7 && a[1:0] == 2'd2) mRise = mRise & ~d;
    if (g == 8 && a[1:0] == 2'd2) mFall = mFall & ~d;
    if (g == 11 && a[1:0] == 2'd1) mTest = d;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setIn(input logic [31:0] v);
    logic [31:0] rEn, fEn;
    rEn = mReg[0] & ~mReg[2];
    fEn = mReg[1] & ~mReg[2];
    @(negedge clk);
    srcIn = v;
    repeat (4) @(negedge clk);
    mRise = mRise | (rEn & v & ~mIn);
    mFall = mFall | (fEn & ~v & mIn);
    mIn = v;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d, p, e0, e1;
    p = expPend();
    e0 = p & mReg[3] & mReg[5];
    e1 = p & mReg[3] & ~mReg[5];
    busRead(6'h24, d); checkVal({tag, " R7 pend0"}, d, e0);
    busRead(6'h28, d); checkVal({tag, " R7 pend1"}, d, e1);
    busRead(6'h1C, d); checkVal({tag, " R2 rise latch"}, d, mRise);
    busRead(6'h20, d); checkVal({tag, " R4 fall latch"}, d, mFall);
    checkVal({tag, " R6 req0"}, {31'd0, req0}, {31'd0, |e0});
    checkVal({tag, " R6 req1"}, {31'd0, req1}, {31'd0, |e1});
    checkVal({tag, " R8 wake"}, {31'd0, wakeOut}, {31'd0, |(p & mReg[4])});
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #1200000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    for (int g = 0; g < 7; g++) mReg[g] = '0;
    mRise = '0; mFall = '0; mTest = '0; mIn = '0;
    rstN = 1'b0; srcIn = '0; busAddr = '0; busWrEn = 1'b0; busWrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    for (int g = 0; g < 7; g++) begin
      busRead(6'(g * 4), d);
      checkVal("R9 control reg after reset", d, 32'd0);
    end
    checkAll("R9 reset");
    setIn(32'hFFFF_FFFF);
    checkAll("R9 inputs high, all codes 000");
    setIn(32'h0);
    checkAll("R5 code 000 captures nothing");

    // R3 set/clear semantics on mask
    busWrite(6'h0D, 32'h0000_00F0);
    busWrite(6'h0D, 32'h0000_000F);
    busWrite(6'h0E, 32'h0000_0030);
    busRead(6'h0C, d); checkVal("R3 mask set/clear", d, 32'h0000_00CF);
    busWrite(6'h0E, 32'hFFFF_FFFF);
    busRead(6'h0C, d); checkVal("R3 mask clear all", d, 32'h0);

    // R1 level-high bit0 to req0, level-low bit1 to req1
    busWrite(6'h09, 32'h3); busWrite(6'h01, 32'h1); busWrite(6'h05, 32'h2);
    busWrite(6'h0D, 32'h3); busWrite(6'h15, 32'h1);
    checkAll("R1 level low active at input 0");
    setIn(32'h3);
    checkAll("R1 level high active");
    setIn(32'h0);
    checkAll("R1 level not latched");

    // R2 rising on bit2, R4 both edges on bit3
    busWrite(6'h01, 32'hC); busWrite(6'h05, 32'h8); busWrite(6'h0D, 32'hC);
    setIn(32'hC);
    setIn(32'h0);
    checkAll("R2 edges held after input idle");
    busWrite(6'h1E, 32'hC);
    checkAll("R4 both-edge held by fall latch");
    busWrite(6'h22, 32'h8);
    checkAll("R4 both-edge acknowledged");

    // R12 reserved codes on bits 4 (100) and 5 (111)
    busWrite(6'h09, 32'h30); busWrite(6'h01, 32'h20); busWrite(6'h05, 32'h20);
    busWrite(6'h0D, 32'h30);
    setIn(32'h30);
    checkAll("R12 reserved codes input high");
    setIn(32'h0);
    checkAll("R12 reserved codes input low");

    // R8 wake without mask on bit0
    busWrite(6'h0E, 32'hFFFF_FFFF);
    busWrite(6'h11, 32'h1);
    setIn(32'h1);
    checkAll("R8 wake independent of mask");
    setIn(32'h0);

    // R10 capture and clear of the same latch bit in one cycle
    busWrite(6'h01, 32'h40);
    busWrite(6'h1E, 32'hFFFF_FFFF);
    @(negedge clk); srcIn = 32'h40;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = 6'h1E; busWrData = 32'h40; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    mIn = 32'h40; mRise = 32'h40;
    busRead(6'h1C, d); checkVal("R10 capture wins over clear", d & 32'h40, 32'h40);
    checkAll("R10 after collision");

    // R11 test register
    busWrite(6'h2D, 32'hA5C3_0F96);
    busRead(6'h2C, d); checkVal("R11 test register", d, mTest);

    // random mix (R1..R8, R12)
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 5);
      if (op < 2) busWrite(6'((($urandom % 7) * 4) + 1 + ($urandom % 2)), $urandom);
      else if (op < 4) setIn(mIn ^ ($urandom & $urandom));
      else busWrite(($urandom % 2) ? 6'h1E : 6'h22, $urandom);
      checkAll("R7 random");
    end
    for (int g = 0; g < 7; g++) begin
      busRead(6'(g * 4), d);
      checkVal("R3 random register readback", d, mReg[g]);
    end
    finishRun();
  end
endmodule